// File: doc/BRIEF.md
# DRAM Access Sequencer with Row Refresh

This block sits between a simple host port and a dynamic RAM array whose row and column addresses share one set of address pins. A host word access is a one-cycle request pulse with a write flag, an address and write data. The block splits the address into a row part (upper bits) and a column part (lower bits). It drives the row and pulls the row strobe low. After a set delay it drives the column and pulls the column strobe low. It then releases both strobes and holds them released for a precharge interval. The block raises busy from the moment it accepts a request. A one-cycle done pulse marks the end of the access and carries the read data.

A free-running interval timer marks a refresh as due. The refresh waits only for an access that is already running. It then starts before any new host request is accepted. A refresh pulls the row strobe low with the column strobe held high. The row it presents comes from a counter that steps through every row in order. The interval is the retention time divided by the row count, minus a margin, so each row is restored well inside the retention window.

Top module: `dram_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, ras_n, cas_n and we_n are high, dq_oe, done and busy are low.
- R2: A request is accepted when req is high in a cycle where busy is low. In the next cycle ras_n is low, mem_addr carries the row (addr bits [ADDR_W-1:COL_W], zero-extended), and busy is high.
- R3: cas_n falls exactly T_RCD cycles after ras_n falls, with mem_addr carrying the column (addr bits [COL_W-1:0]). cas_n is low only while ras_n is low.
- R4: On a write (we=1), the column phase lasts T_CAS cycles with we_n low, dq_oe high and dq_out equal to the write data. dq_oe is high only then.
- R5: done is a single-cycle pulse that appears T_RCD+T_CAS cycles after the accepting edge. After a read (we=0), rdata equals the value last written to that address.
- R6: After any access or refresh, ras_n stays high for at least T_RP cycles before it falls again.
- R7: A req raised while busy is high is ignored. It starts no access, produces no done pulse and changes no stored data.
- R8: After reset, a refresh comes due every REF_INTERVAL cycles. The first one, when the host is idle, lowers ras_n in cycle REF_INTERVAL+1. A refresh keeps ras_n low for exactly T_RAS cycles with cas_n high, and presents rows 0, 1, 2 ... in order, wrapping around.
- R9: A refresh that comes due is held only for a running access. It starts at most 1+T_RCD+T_CAS+T_RP cycles after the due point, and busy stays high while it is pending.
- R10: Every row is refreshed again within RETENTION_CYC cycles of its previous refresh, or of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request pulse, taken when busy is low |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W+COL_W | Word address: row in the upper bits, column in the lower |
| wdata | input | DATA_W | Write data |
| busy | output | 1 | Block cannot accept a request |
| done | output | 1 | One-cycle access completion |
| rdata | output | DATA_W | Read data, valid with done after a read |
| mem_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Array write enable, active low |
| dq_out | output | DATA_W | Data driven to the array |
| dq_oe | output | 1 | Enable for dq_out |
| dq_in | input | DATA_W | Data returned by the array |

## Verification
A cycle-based array model in the bench latches the row and column from the shared pins, stores written words and returns reads. It also times every strobe edge. The first host pattern is a long random mix of reads and writes with gaps of zero to two cycles over the whole address space. Back-to-back requests test whether the precharge gap is kept. Reads of earlier writes show whether row and column land in the right halves. The random timing also places host accesses at every point in the refresh interval, which shows whether a due refresh waits for a running access and is never pushed past it. Directed cases cover the idle first refresh, whose start cycle must be exact, and requests injected while busy, whose target words must stay untouched.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_REF,
      ST_PRE
   } seq_state_t;

   function automatic int unsigned cnt_bits(input int unsigned top);
      return (top < 2) ? 1 : $clog2(top + 1);
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int unsigned ROW_W    = 4,
   parameter int unsigned INTERVAL = 224
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_start,
   input  logic             ref_end,
   output logic             ref_due,
   output logic [ROW_W-1:0] ref_row
);
   localparam int unsigned TW = dram_ctrl_pkg::cnt_bits(INTERVAL - 1);
   localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

   logic [TW-1:0] tmr_q;
   logic          tick;

   assign tick = (tmr_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q <= '0;
      end else if (tick) begin
         tmr_q <= '0;
      end else begin
         tmr_q <= tmr_q + 1'b1;
      end
   end

   // a tick in the start cycle wins: the new period is still owed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_due <= 1'b0;
      end else if (tick) begin
         ref_due <= 1'b1;
      end else if (ref_start) begin
         ref_due <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_row <= '0;
      end else if (ref_end) begin
         ref_row <= ref_row + 1'b1;
      end
   end

endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
   parameter int unsigned ROW_W = 4,
   parameter int unsigned COL_W = 4,
   parameter int unsigned MUX_W = 4
) (
   input  logic [ROW_W+COL_W-1:0] addr,
   input  logic [ROW_W-1:0]       ref_row,
   output logic [MUX_W-1:0]       row_bus,
   output logic [MUX_W-1:0]       col_bus,
   output logic [MUX_W-1:0]       ref_bus
);
   localparam int unsigned ADDR_W = ROW_W + COL_W;

   logic [ROW_W-1:0] row_part;
   logic [COL_W-1:0] col_part;

   assign row_part = addr[ADDR_W-1:COL_W];
   assign col_part = addr[COL_W-1:0];

   generate
      if (ROW_W == MUX_W) begin : g_row_full
         assign row_bus = row_part;
         assign ref_bus = ref_row;
      end else begin : g_row_pad
         assign row_bus = {{(MUX_W-ROW_W){1'b0}}, row_part};
         assign ref_bus = {{(MUX_W-ROW_W){1'b0}}, ref_row};
      end

      if (COL_W == MUX_W) begin : g_col_full
         assign col_bus = col_part;
      end else begin : g_col_pad
         assign col_bus = {{(MUX_W-COL_W){1'b0}}, col_part};
      end
   endgenerate

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
   import dram_ctrl_pkg::*;
#(
   parameter int unsigned MUX_W  = 4,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned T_RCD  = 2,
   parameter int unsigned T_CAS  = 2,
   parameter int unsigned T_RAS  = 3,
   parameter int unsigned T_RP   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [MUX_W-1:0]  row_bus,
   input  logic [MUX_W-1:0]  col_bus,
   input  logic [MUX_W-1:0]  ref_bus,
   input  logic              ref_due,
   input  logic [DATA_W-1:0] dq_in,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [MUX_W-1:0]  mem_addr,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic              ref_start,
   output logic              ref_end
);
   localparam int unsigned TMAX = max2(max2(T_RCD, T_CAS), max2(T_RAS, T_RP));
   localparam int unsigned CW   = cnt_bits(TMAX);
   localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
   localparam logic [CW-1:0] LD_CAS = CW'(T_CAS - 1);
   localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
   localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);

   seq_state_t        st;
   logic [CW-1:0]     cnt;
   logic              cnt_zero;
   logic [MUX_W-1:0]  col_q;
   logic              wr_q;

   assign cnt_zero  = (cnt == '0);
   assign busy      = (st != ST_IDLE) || ref_due;
   assign ref_start = (st == ST_IDLE) && ref_due;
   assign ref_end   = (st == ST_REF) && cnt_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         col_q    <= '0;
         wr_q     <= 1'b0;
         mem_addr <= '0;
         ras_n    <= 1'b1;
         cas_n    <= 1'b1;
         we_n     <= 1'b1;
         dq_oe    <= 1'b0;
         dq_out   <= '0;
         done     <= 1'b0;
         rdata    <= '0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (ref_due) begin
                  st       <= ST_REF;
                  ras_n    <= 1'b0;
                  mem_addr <= ref_bus;
                  cnt      <= LD_RAS;
               end else if (req) begin
                  st       <= ST_ROW;
                  ras_n    <= 1'b0;
                  mem_addr <= row_bus;
                  col_q    <= col_bus;
                  wr_q     <= we;
                  dq_out   <= wdata;
                  cnt      <= LD_RCD;
               end
            end
            ST_ROW: begin
               if (cnt_zero) begin
                  st       <= ST_COL;
                  cas_n    <= 1'b0;
                  mem_addr <= col_q;
                  we_n     <= ~wr_q;
                  dq_oe    <= wr_q;
                  cnt      <= LD_CAS;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_COL: begin
               if (cnt_zero) begin
                  st    <= ST_PRE;
                  ras_n <= 1'b1;
                  cas_n <= 1'b1;
                  we_n  <= 1'b1;
                  dq_oe <= 1'b0;
                  done  <= 1'b1;
                  if (!wr_q) begin
                     rdata <= dq_in;
                  end
                  cnt   <= LD_RP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_REF: begin
               if (cnt_zero) begin
                  st    <= ST_PRE;
                  ras_n <= 1'b1;
                  cnt   <= LD_RP;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_PRE: begin
               if (cnt_zero) begin
                  st <= ST_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl #(
   parameter int unsigned ROW_W         = 4,
   parameter int unsigned COL_W         = 4,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned T_RCD         = 2,
   parameter int unsigned T_CAS         = 2,
   parameter int unsigned T_RAS         = 3,
   parameter int unsigned T_RP          = 2,
   parameter int unsigned RETENTION_CYC = 4096,
   parameter int unsigned REF_MARGIN    = 32,
   localparam int unsigned ADDR_W       = ROW_W + COL_W,
   localparam int unsigned MUX_W        = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [MUX_W-1:0]  mem_addr,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   input  logic [DATA_W-1:0] dq_in
);
   localparam int unsigned NUM_ROWS     = 1 << ROW_W;
   localparam int unsigned REF_INTERVAL = RETENTION_CYC / NUM_ROWS - REF_MARGIN;
   localparam int unsigned MAX_HOLD     = T_RCD + T_CAS + T_RP + 1;

   generate
      if (T_RCD < 1 || T_CAS < 1 || T_RAS < 1 || T_RP < 1) begin : g_bad_timing
         $error("timing parameters must be at least one cycle");
      end
      if (RETENTION_CYC / NUM_ROWS <= REF_MARGIN + T_RAS + T_RP + MAX_HOLD) begin : g_bad_interval
         $error("refresh interval too short for one refresh plus one access");
      end
      if (NUM_ROWS * REF_INTERVAL + MAX_HOLD + T_RAS > RETENTION_CYC) begin : g_bad_sweep
         $error("a full refresh sweep does not fit in the retention window");
      end
   endgenerate

   logic [MUX_W-1:0] row_bus;
   logic [MUX_W-1:0] col_bus;
   logic [MUX_W-1:0] ref_bus;
   logic [ROW_W-1:0] ref_row;
   logic             ref_due;
   logic             ref_start;
   logic             ref_end;

   dram_refresh_timer #(
      .ROW_W    (ROW_W),
      .INTERVAL (REF_INTERVAL)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_start (ref_start),
      .ref_end   (ref_end),
      .ref_due   (ref_due),
      .ref_row   (ref_row)
   );

   dram_addr_split #(
      .ROW_W (ROW_W),
      .COL_W (COL_W),
      .MUX_W (MUX_W)
   ) u_split (
      .addr    (addr),
      .ref_row (ref_row),
      .row_bus (row_bus),
      .col_bus (col_bus),
      .ref_bus (ref_bus)
   );

   dram_access_seq #(
      .MUX_W  (MUX_W),
      .DATA_W (DATA_W),
      .T_RCD  (T_RCD),
      .T_CAS  (T_CAS),
      .T_RAS  (T_RAS),
      .T_RP   (T_RP)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .we        (we),
      .wdata     (wdata),
      .row_bus   (row_bus),
      .col_bus   (col_bus),
      .ref_bus   (ref_bus),
      .ref_due   (ref_due),
      .dq_in     (dq_in),
      .busy      (busy),
      .done      (done),
      .rdata     (rdata),
      .mem_addr  (mem_addr),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .dq_out    (dq_out),
      .dq_oe     (dq_oe),
      .ref_start (ref_start),
      .ref_end   (ref_end)
   );

endmodule

// File: rtl/dram_seq_ctrl_chk.sv
module dram_seq_ctrl_chk #(
   parameter int unsigned T_RCD = 2,
   parameter int unsigned T_RP  = 2
) (
   input logic clk,
   input logic rst_n,
   input logic req,
   input logic busy,
   input logic done,
   input logic ras_n,
   input logic cas_n,
   input logic we_n,
   input logic dq_oe
);
   logic [7:0] lo_c;
   logic [7:0] hi_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_c <= '0;
         hi_c <= 8'(T_RP);
      end else begin
         lo_c <= ras_n ? 8'd0 : ((lo_c == 8'hFF) ? lo_c : lo_c + 8'd1);
         hi_c <= !ras_n ? 8'd0 : ((hi_c == 8'hFF) ? hi_c : hi_c + 8'd1);
      end
   end

   // R2
   accept_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> (!ras_n && busy));

   // R3
   col_inside_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   // R3
   row_to_col_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> (lo_c == 8'(T_RCD)));

   // R4
   drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!cas_n && !we_n));

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (hi_c >= 8'(T_RP)));

endmodule

bind dram_seq_ctrl dram_seq_ctrl_chk #(
   .T_RCD (T_RCD),
   .T_RP  (T_RP)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .req   (req),
   .busy  (busy),
   .done  (done),
   .ras_n (ras_n),
   .cas_n (cas_n),
   .we_n  (we_n),
   .dq_oe (dq_oe)
);

// File: tb/tb_dram_seq_ctrl.sv
`timescale 1ns/100ps
module tb_dram_seq_ctrl;
   localparam int ROW_W = 4;
   localparam int COL_W = 4;
   localparam int DW    = 8;
   localparam int AW    = ROW_W + COL_W;
   localparam int T_RCD = 2;
   localparam int T_CAS = 2;
   localparam int T_RAS = 3;
   localparam int T_RP  = 2;
   localparam int RET   = 4096;
   localparam int MARG  = 32;
   localparam int ROWS  = 1 << ROW_W;
   localparam int REF_INTERVAL = RET / ROWS - MARG;
   localparam int MAX_OFF = 1 + T_RCD + T_CAS + T_RP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic we = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic busy, done, ras_n, cas_n, we_n, dq_oe;
   logic [DW-1:0] rdata, dq_out, dq_in;
   logic [3:0] mem_addr;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dram_seq_ctrl #(
      .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
      .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP),
      .RETENTION_CYC(RET), .REF_MARGIN(MARG)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_out(dq_out),
      .dq_oe(dq_oe), .dq_in(dq_in)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // ---------------- array model, evaluated on the falling clock edge
   logic [DW-1:0] mem [256];
   logic [DW-1:0] exp_mem [256];
   logic [ROW_W-1:0] lrow = '0;
   logic prev_ras = 1'b1;
   logic prev_cas = 1'b1;
   bit   cas_seen = 1'b0;
   int   lo_cnt = 0;
   int   hi_cnt = 1000;
   int   cyc = 0;
   int   fall_cyc = 0;
   int   ref_count = 0;
   int   first_ref_cyc = 0;
   int   exp_row = 0;
   int   age [ROWS];

   assign dq_in = (!cas_n && we_n) ? mem[{lrow, mem_addr[COL_W-1:0]}] : 8'h5A;

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i] = '0;
         exp_mem[i] = '0;
      end
      for (int r = 0; r < ROWS; r++) age[r] = 0;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         for (int r = 0; r < ROWS; r++) age[r]++;
         if (!ras_n && prev_ras) begin
            // R6 precharge time before every row open
            chk(hi_cnt >= T_RP, "R6 ras high cycles", hi_cnt, T_RP);
            lrow = mem_addr[ROW_W-1:0];
            lo_cnt = 1;
            cas_seen = 1'b0;
            fall_cyc = cyc;
         end else if (!ras_n) begin
            lo_cnt++;
         end
         if (!cas_n && prev_cas) begin
            // R3 row to column delay
            chk(!ras_n && lo_cnt == T_RCD + 1, "R3 ras-to-cas", lo_cnt - 1, T_RCD);
            cas_seen = 1'b1;
         end
         if (!cas_n && ras_n) chk(1'b0, "R3 cas outside ras", 1, 0);
         if (!cas_n && !we_n) mem[{lrow, mem_addr[COL_W-1:0]}] = dq_out;
         if (ras_n && !prev_ras) begin
            if (!cas_seen) begin
               ref_count++;
               if (ref_count == 1) first_ref_cyc = fall_cyc;
               chk(int'(lrow) == exp_row, "R8 refresh row order", lrow, exp_row);
               chk(lo_cnt == T_RAS, "R8 refresh ras width", lo_cnt, T_RAS);
               chk(fall_cyc - ref_count * REF_INTERVAL >= 1 &&
                   fall_cyc - ref_count * REF_INTERVAL <= MAX_OFF,
                   "R9 refresh start offset", fall_cyc - ref_count * REF_INTERVAL, MAX_OFF);
               chk(age[lrow] <= RET, "R10 row age at refresh", age[lrow], RET);
               age[lrow] = 0;
               exp_row = (exp_row + 1) % ROWS;
            end
            hi_cnt = 1;
         end else if (ras_n) begin
            hi_cnt++;
         end
         prev_ras = ras_n;
         prev_cas = cas_n;
      end
   end

   // ---------------- host side
   task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit inject);
      int lat;
      int dones;
      logic [AW-1:0] ia;
      ia = a ^ 8'h01;
      @(negedge clk);
      while (busy) @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(negedge clk);
      req = 1'b0;
      lat = 1;
      chk(!ras_n && busy, "R2 row open after accept", {ras_n, busy}, 2'b01);
      chk(mem_addr == 4'(a[AW-1:COL_W]), "R2 row on address pins", mem_addr, a[AW-1:COL_W]);
      if (inject) begin
         req = 1'b1; we = 1'b1; addr = ia; wdata = ~d;
      end
      while (!done) begin
         @(negedge clk);
         req = 1'b0;
         lat++;
         if (lat == T_RCD + 1) begin
            chk(!cas_n && mem_addr == 4'(a[COL_W-1:0]), "R3 column on pins",
                mem_addr, a[COL_W-1:0]);
            if (w) chk(!we_n && dq_oe && dq_out == d, "R4 write drive", dq_out, d);
            else   chk(we_n && !dq_oe, "R4 no drive on read", {we_n, dq_oe}, 2'b10);
         end
         if (lat > 64) break;
      end
      chk(lat == T_RCD + T_CAS + 1, "R5 done latency", lat - 1, T_RCD + T_CAS);
      if (!w) chk(rdata == exp_mem[a], "R5 read data", rdata, exp_mem[a]);
      else exp_mem[a] = d;
      @(negedge clk);
      chk(!done, "R5 done one cycle", done, 0);
      if (inject) begin
         dones = 0;
         for (int k = 0; k < T_RP + 4; k++) begin
            @(negedge clk);
            if (done) dones++;
         end
         chk(dones == 0, "R7 request while busy ignored", dones, 0);
         access(1'b0, ia, '0, 1'b0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ras_n && cas_n && we_n && !dq_oe && !done && !busy, "R1 reset outputs",
          {ras_n, cas_n, we_n, dq_oe, done, busy}, 6'b111000);
      @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(ras_n && cas_n && !busy, "R1 after reset", {ras_n, cas_n, busy}, 3'b110);

      // R8 first refresh with idle host starts at an exact cycle
      while (ref_count == 0) @(negedge clk);
      chk(first_ref_cyc == REF_INTERVAL + 1, "R8 first refresh cycle",
          first_ref_cyc, REF_INTERVAL + 1);

      // directed corners: lowest and highest address, write then read
      access(1'b1, 8'h00, 8'hC3, 1'b0);
      access(1'b1, 8'hFF, 8'h3C, 1'b0);
      access(1'b0, 8'h00, '0, 1'b0);
      access(1'b0, 8'hFF, '0, 1'b0);
      // R7 injections during busy
      access(1'b1, 8'h40, 8'h11, 1'b1);
      access(1'b0, 8'h40, '0, 1'b1);

      // random traffic
      for (int n = 0; n < 1500; n++) begin
         logic [AW-1:0] ra;
         ra = AW'($urandom % 256);
         access(1'($urandom % 2), ra, DW'($urandom), ($urandom % 20) == 0);
         repeat ($urandom % 3) @(negedge clk);
      end

      // R10 a full sweep happened and no row is older than the window
      chk(ref_count >= 2 * ROWS, "R10 sweeps completed", ref_count, 2 * ROWS);
      for (int r = 0; r < ROWS; r++)
         chk(age[r] <= RET, "R10 final row age", age[r], RET);
      finish_run();
   end

endmodule